// File: doc/BRIEF.md
# Byte-Lane Swap Buffer

This block sits between a 32-bit system bus divided into byte lanes and an internal 32-bit data port. It exists for transfers where the two agents on a bus cycle differ in width. Each incoming bus byte is captured into its own swap latch under a per-lane latch enable. The latched word is always visible, unchanged, on the internal read port.

The same latched bytes can be driven back onto the system bus. On the way out, a byte may be copied from one lane onto another. This serves mismatched-width cycles between bus agents and DMA between bus devices. Copying uses four fixed lane pairings and one shared direction input. Three output enables gate the re-driven bytes; the third one covers both upper lanes.

External control logic decides which latch, copy and output enables to assert. It is also responsible for assembling words over several cycles. The bus is modelled as a separate input vector, output vector and per-byte enable vector, with no tristate.

Top module: `lane_swap_buffer`

## Requirements
- R1: On a rising clock edge with reset low, each lane whose bit in `lane_le` is 1 loads the matching byte of `bus_din` (lane n is bits 8n+7..8n).
- R2: A lane whose `lane_le` bit is 0 keeps its latched byte, whatever `bus_din` does.
- R3: A rising edge with `rst` high clears every latched byte to zero. Reset takes priority over `lane_le`.
- R4: `int_rdata` always equals the four latched bytes in lane order, whatever the copy, direction or output-enable inputs are.
- R5: The copy enables select fixed pairs: `copy_en[0]` pairs lanes 0 and 1, `[1]` pairs 0 and 2, `[2]` pairs 0 and 3, and `[3]` pairs 1 and 3. With `copy_up` = 1, the lower lane of an active pair is copied onto its higher lane.
- R6: With `copy_up` = 0, the higher lane of each active pair is copied onto its lower lane.
- R7: When several active pairs target the same lane, the pair with the lowest `copy_en` index supplies the byte.
- R8: A lane that no active pair targets drives its own latched byte. Copy sources are always latched bytes, never the result of another copy.
- R9: `oe_grp[0]` enables lane 0 and `oe_grp[1]` enables lane 1. `oe_grp[2]` enables lanes 2 and 3 together. `bus_oe` shows the resulting enable for each lane.
- R10: A lane whose output enable is off drives zero on `bus_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the latches load on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_din | input | 32 | Byte-laned data arriving from the system bus |
| lane_le | input | 4 | Latch enable, one bit per lane |
| copy_en | input | 4 | Copy-pair enables |
| copy_up | input | 1 | Copy direction: 1 copies lower lane to higher lane, 0 copies higher lane to lower lane |
| oe_grp | input | 3 | Grouped output enables: lane 0, lane 1, lanes 2 and 3 |
| bus_dout | output | 32 | Re-drive data toward the system bus |
| bus_oe | output | 4 | Output enable for each lane |
| int_rdata | output | 32 | Latched word presented to the internal port |

## Verification
The hardest cases to reach are those where one lane is both the target of one active pair and the source of another. Examples are pairs 0 and 3 together in either direction, and two pairs converging on lane 3 or lane 0. A wrong design could chain copies or pick the wrong priority there and still look correct on simple patterns. The bench loads a different value into every lane, so the origin of each output byte can be identified. It then steps a vector table through single pairs, converging pairs and pairs that share a lane, in both directions. Directed tests cover partial lane loads, holding, and reset racing a load.

// File: rtl/swap_pkg.sv
package swap_pkg;

   // number of fixed copy pairings
   localparam int PAIR_COUNT = 4;

   // lower lane of pairing k
   function automatic int pair_low(input int k);
      case (k)
         3:       return 1;
         default: return 0;
      endcase
   endfunction

   // higher lane of pairing k
   function automatic int pair_high(input int k);
      case (k)
         0:       return 1;
         1:       return 2;
         default: return 3;
      endcase
   endfunction

   // output-enable group that drives a lane
   function automatic int lane_group(input int lane);
      return (lane >= 2) ? 2 : lane;
   endfunction

endpackage

// File: rtl/swap_latch_bank.sv
module swap_latch_bank #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [LANES-1:0][BYTE_W-1:0]  din,
   input  logic [LANES-1:0]              le,
   output logic [LANES-1:0][BYTE_W-1:0]  q
);

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)
            q[n] <= '0;
         else if (le[n])
            q[n] <= din[n];
      end

      p_load_r1: assert property (@(posedge clk) disable iff (rst)
         (le[n]) |=> (q[n] == $past(din[n])));

      p_hold_r2: assert property (@(posedge clk) disable iff (rst)
         (!le[n]) |=> $stable(q[n]));

      p_clear_r3: assert property (@(posedge clk)
         rst |=> (q[n] == '0));
   end

endmodule

// File: rtl/swap_copy_mux.sv
module swap_copy_mux
   import swap_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int PAIRS  = PAIR_COUNT
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [LANES-1:0][BYTE_W-1:0]  lat,
   input  logic [PAIRS-1:0]              copy_en,
   input  logic                          copy_up,
   output logic [LANES-1:0][BYTE_W-1:0]  mixed
);

   for (genvar d = 0; d < LANES; d++) begin : g_dest
      always_comb begin
         logic taken;
         int   src;
         taken = 1'b0;
         src   = d;
         for (int k = 0; k < PAIRS; k++) begin
            if (!taken && copy_en[k] &&
                ((copy_up ? pair_high(k) : pair_low(k)) == d)) begin
               taken = 1'b1;
               src   = copy_up ? pair_low(k) : pair_high(k);
            end
         end
         mixed[d] = lat[d];
         for (int s = 0; s < LANES; s++) begin
            if (s == src) mixed[d] = lat[s];
         end
      end
   end

   // lane 3 in the up direction: pair 2 outranks pair 3
   p_prio_up_r7: assert property (@(posedge clk) disable iff (rst)
      (copy_up && copy_en[2]) |-> (mixed[3] == lat[0]));

   // lane 0 in the down direction: pair 0 outranks the others
   p_prio_down_r7: assert property (@(posedge clk) disable iff (rst)
      (!copy_up && copy_en[0]) |-> (mixed[0] == lat[1]));

   p_down_pair3_r6: assert property (@(posedge clk) disable iff (rst)
      (!copy_up && copy_en[3]) |-> (mixed[1] == lat[3]));

   p_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (copy_en == '0) |-> (mixed == lat));

endmodule

// File: rtl/swap_oe_expand.sv
module swap_oe_expand
   import swap_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int GROUPS = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [GROUPS-1:0]             oe_grp,
   input  logic [LANES-1:0][BYTE_W-1:0]  mixed,
   output logic [LANES-1:0]              lane_oe,
   output logic [LANES-1:0][BYTE_W-1:0]  dout
);

   for (genvar d = 0; d < LANES; d++) begin : g_out
      localparam int GRP = lane_group(d);
      assign lane_oe[d] = oe_grp[GRP];
      assign dout[d]    = lane_oe[d] ? mixed[d] : '0;
   end

   p_upper_pair_r9: assert property (@(posedge clk) disable iff (rst)
      lane_oe[3] == lane_oe[2]);

endmodule

// File: rtl/lane_swap_buffer.sv
module lane_swap_buffer
   import swap_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int GROUPS = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [LANES*BYTE_W-1:0]   bus_din,
   input  logic [LANES-1:0]          lane_le,
   input  logic [PAIR_COUNT-1:0]     copy_en,
   input  logic                      copy_up,
   input  logic [GROUPS-1:0]         oe_grp,
   output logic [LANES*BYTE_W-1:0]   bus_dout,
   output logic [LANES-1:0]          bus_oe,
   output logic [LANES*BYTE_W-1:0]   int_rdata
);

   localparam int DATA_W = LANES * BYTE_W;

   initial begin
      a_lanes: assert (LANES == 4)
         else $error("lane_swap_buffer: the pairings assume four lanes");
      a_groups: assert (GROUPS == 3)
         else $error("lane_swap_buffer: three output-enable groups expected");
      a_byte: assert (BYTE_W > 0)
         else $error("lane_swap_buffer: byte width must be positive");
   end

   logic [LANES-1:0][BYTE_W-1:0] din_v, lat_v, mix_v, out_v;

   assign din_v = bus_din;

   swap_latch_bank #(.BYTE_W(BYTE_W), .LANES(LANES)) u_latch (
      .clk (clk), .rst (rst), .din (din_v), .le (lane_le), .q (lat_v)
   );

   swap_copy_mux #(.BYTE_W(BYTE_W), .LANES(LANES), .PAIRS(PAIR_COUNT)) u_copy (
      .clk (clk), .rst (rst), .lat (lat_v), .copy_en (copy_en),
      .copy_up (copy_up), .mixed (mix_v)
   );

   swap_oe_expand #(.BYTE_W(BYTE_W), .LANES(LANES), .GROUPS(GROUPS)) u_oe (
      .clk (clk), .rst (rst), .oe_grp (oe_grp), .mixed (mix_v),
      .lane_oe (bus_oe), .dout (out_v)
   );

   assign bus_dout  = DATA_W'(out_v);
   assign int_rdata = DATA_W'(lat_v);

   for (genvar d = 0; d < LANES; d++) begin : g_chk
      p_gate_zero_r10: assert property (@(posedge clk) disable iff (rst)
         (!bus_oe[d]) |-> (bus_dout[d*BYTE_W +: BYTE_W] == '0));
   end

   p_passthru_r4: assert property (@(posedge clk) disable iff (rst)
      (&lane_le) |=> (int_rdata == $past(bus_din)));

   p_copy_up_r5: assert property (@(posedge clk) disable iff (rst)
      (copy_up && copy_en[0] && oe_grp[1]) |->
         (bus_dout[2*BYTE_W-1:BYTE_W] == int_rdata[BYTE_W-1:0]));

endmodule

// File: tb/lane_swap_buffer_tb_top.sv
module lane_swap_buffer_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] bus_din = '0;
   logic [3:0]  lane_le = '0;
   logic [3:0]  copy_en = '0;
   logic        copy_up = 1'b0;
   logic [2:0]  oe_grp  = '0;
   logic [31:0] bus_dout, int_rdata;
   logic [3:0]  bus_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   lane_swap_buffer dut_i (
      .clk (clk), .rst (rst), .bus_din (bus_din), .lane_le (lane_le),
      .copy_en (copy_en), .copy_up (copy_up), .oe_grp (oe_grp),
      .bus_dout (bus_dout), .bus_oe (bus_oe), .int_rdata (int_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // {copy_en, copy_up, oe_grp, expected bus_dout, expected bus_oe}
   // latches hold lane3..0 = 44 33 22 11
   localparam int NV = 18;
   localparam logic [43:0] VEC [NV] = '{
      {4'b0000, 1'b1, 3'b111, 32'h44332211, 4'b1111},  // R8 no copy
      {4'b0001, 1'b1, 3'b111, 32'h44331111, 4'b1111},  // R5 0->1
      {4'b0010, 1'b1, 3'b111, 32'h44112211, 4'b1111},  // R5 0->2
      {4'b0100, 1'b1, 3'b111, 32'h11332211, 4'b1111},  // R5 0->3
      {4'b1000, 1'b1, 3'b111, 32'h22332211, 4'b1111},  // R5 1->3
      {4'b1100, 1'b1, 3'b111, 32'h11332211, 4'b1111},  // R7 lane3 up
      {4'b0001, 1'b0, 3'b111, 32'h44332222, 4'b1111},  // R6 1->0
      {4'b0010, 1'b0, 3'b111, 32'h44332233, 4'b1111},  // R6 2->0
      {4'b0100, 1'b0, 3'b111, 32'h44332244, 4'b1111},  // R6 3->0
      {4'b1000, 1'b0, 3'b111, 32'h44334411, 4'b1111},  // R6 3->1
      {4'b0111, 1'b0, 3'b111, 32'h44332222, 4'b1111},  // R7 lane0 down
      {4'b1001, 1'b1, 3'b111, 32'h22331111, 4'b1111},  // R8 no chaining up
      {4'b1001, 1'b0, 3'b111, 32'h44334422, 4'b1111},  // R8 no chaining down
      {4'b0000, 1'b0, 3'b001, 32'h00000011, 4'b0001},  // R9 R10 lane0 only
      {4'b0000, 1'b0, 3'b010, 32'h00002200, 4'b0010},  // R9 R10 lane1 only
      {4'b0000, 1'b0, 3'b100, 32'h44330000, 4'b1100},  // R9 upper pair
      {4'b0000, 1'b0, 3'b000, 32'h00000000, 4'b0000},  // R10 all off
      {4'b1111, 1'b1, 3'b110, 32'h11111100, 4'b1110}   // R7 R10 mixed
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset racing a full load: reset must win (R3)
      bus_din = 32'hFFFF_FFFF;
      lane_le = 4'hF;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0; lane_le = '0; oe_grp = 3'b111;
      #1;
      chk("R3 reset clears latches", int_rdata, 32'h0);
      chk("R10 output after reset", bus_dout, 32'h0);

      // full load (R1)
      @(negedge clk);
      bus_din = 32'h44332211; lane_le = 4'hF;
      @(negedge clk);
      lane_le = '0; bus_din = 32'hDEADBEEF;
      #1;
      chk("R1 full load", int_rdata, 32'h44332211);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {copy_en, copy_up, oe_grp} = VEC[i][43:36];
         #1;
         chk($sformatf("R5-R10 vector %0d dout", i), bus_dout, VEC[i][35:4]);
         chk($sformatf("R9 vector %0d oe", i), {28'h0, bus_oe}, {28'h0, VEC[i][3:0]});
         chk($sformatf("R4 vector %0d internal", i), int_rdata, 32'h44332211);
      end

      // partial load of lanes 0 and 2 (R1, R2)
      @(negedge clk);
      copy_en = '0; oe_grp = 3'b111;
      bus_din = 32'hAABBCCDD; lane_le = 4'b0101;
      @(negedge clk);
      lane_le = '0;
      #1;
      chk("R1 R2 partial load", int_rdata, 32'h44BB22DD);

      // input changes with no latch enable (R2)
      @(negedge clk);
      bus_din = 32'h12345678;
      @(negedge clk);
      #1;
      chk("R2 hold without enable", int_rdata, 32'h44BB22DD);
      chk("R2 hold seen on bus", bus_dout, 32'h44BB22DD);

      // down copy from a partially reloaded lane (R6)
      copy_en = 4'b1000; copy_up = 1'b0;
      #1;
      chk("R6 lane1 from lane3", bus_dout, 32'h44BB44DD);

      // reset with load request pending (R3)
      @(negedge clk);
      copy_en = '0; rst = 1'b1; lane_le = 4'hF; bus_din = 32'h55555555;
      @(negedge clk);
      rst = 1'b0; lane_le = '0;
      #1;
      chk("R3 mid-run reset", int_rdata, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule